// File: doc/BRIEF.md
# Sliding-Scale ADC Linearity Corrector

This block is the digital half of a sliding-scale linearization loop placed around an external analog-to-digital converter. When a conversion is requested, it draws a pseudo-random offset code and presents it to an external DAC, whose output is summed with the sampled analog input. The converter then digitizes the input plus that offset, so each conversion lands on a different, randomly chosen region of the converter's transfer curve. Averaged over many conversions, the unequal widths of individual code bins are smoothed out. The technique suits any converter type, and flash and successive-approximation converters gain the most from it.

When the converter reports its raw code, the block subtracts the same offset code and returns a corrected code. The offset is known exactly, so the subtraction restores the nominal value of the input. The usable input span is reduced by the offset headroom. The corrected output is therefore limited to the range 0 to MAXC = 2^N - 2^K, where N is the converter width and K is the offset width. A result outside that range is clamped and flagged.

Top module: `slide_scale_corr`

## Requirements
- R1: While `rst` is high at a rising clock edge, `dither_valid_o`, `out_valid_o` and `out_clip_o` go to 0, and `dither_code_o` and `out_code_o` go to 0.
- R2: A `conv_start_i` pulse seen while idle (`dither_valid_o` low) makes `dither_valid_o` high from the next cycle on.
- R3: The offset source is a 16-bit Fibonacci shift register. It is seeded with 0xACE1 on reset. Each step shifts it left by one and inserts, at bit 0, the XOR of bits 15, 13, 12 and 10. Each accepted start presents the current state's low K bits as the offset and then steps the register exactly once. A start seen while busy is ignored and does not step the register.
- R4: `dither_code_o` holds its value from the accepted start until the next accepted start, including the whole period in which `dither_valid_o` is high.
- R5: `adc_done_i` seen while busy clears `dither_valid_o` from the next cycle on. In that same next cycle, `out_valid_o` pulses high for exactly one cycle. When the difference D = `adc_code_i` - offset lies in 0..MAXC, `out_code_o` = D and `out_clip_o` = 0.
- R6: When D is negative, `out_code_o` = 0 and `out_clip_o` = 1.
- R7: When D is greater than MAXC, `out_code_o` = MAXC and `out_clip_o` = 1 (with defaults N=8 and K=5, MAXC = 224).
- R8: `adc_done_i` seen while idle is ignored: `out_valid_o` stays low and `out_code_o` and `out_clip_o` do not change.
- R9: `out_code_o` and `out_clip_o` hold their last values between result pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_start_i | input | 1 | Request a new conversion |
| dither_code_o | output | K | Offset code for the external DAC |
| dither_valid_o | output | 1 | High while a conversion is pending and the offset is in use |
| adc_code_i | input | N | Raw converter result |
| adc_done_i | input | 1 | Raw result is valid this cycle |
| out_code_o | output | N | Corrected code |
| out_valid_o | output | 1 | One-cycle strobe for a new corrected code |
| out_clip_o | output | 1 | Corrected code was clamped at either end |

## Verification
The assertions assume that reset is held through the first clock edge and that the strobes and the raw code carry known values at every edge. They also assume that the converter's raw code is only meaningful in the cycle its done strobe is high. The stimulus drives every input on the falling edge. It derives the raw code from the offset the block is presenting plus a chosen input level, or forces it to zero or to full scale to reach both clamps. It also issues spurious starts during a pending conversion and done strobes while idle.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

    localparam int          LFSR_W    = 16;
    localparam logic [15:0] LFSR_SEED = 16'hACE1;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } ssc_state_e;

    // One step of the maximal-length sequence x^16 + x^14 + x^13 + x^11 + 1
    function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
        logic fb;
        fb = s[15] ^ s[13] ^ s[12] ^ s[10];
        return {s[LFSR_W-2:0], fb};
    endfunction

endpackage

// File: rtl/ssc_lfsr.sv
module ssc_lfsr #(
    parameter int K = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv_i,
    output logic [K-1:0] low_o
);
    import ssc_pkg::*;

    logic [LFSR_W-1:0] state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LFSR_SEED;
        end else if (adv_i) begin
            state_q <= lfsr_step(state_q);
        end
    end

    assign low_o = state_q[K-1:0];

endmodule

// File: rtl/ssc_ctrl.sv
module ssc_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic done_i,
    output logic take_o,
    output logic finish_o,
    output logic hold_o
);
    import ssc_pkg::*;

    ssc_state_e state_q;

    // A start is only honoured when idle; a done only while holding.
    assign take_o   = start_i && (state_q == ST_IDLE);
    assign finish_o = done_i  && (state_q == ST_HOLD);
    assign hold_o   = (state_q == ST_HOLD);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else if (take_o) begin
            state_q <= ST_HOLD;
        end else if (finish_o) begin
            state_q <= ST_IDLE;
        end
    end

endmodule

// File: rtl/ssc_corrector.sv
module ssc_corrector #(
    parameter int N = 8,
    parameter int K = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [N-1:0] raw_i,
    input  logic [K-1:0] ofs_i,
    output logic [N-1:0] code_o,
    output logic         clip_o,
    output logic         valid_o
);
    localparam int          MAXC_I = (1 << N) - (1 << K);
    localparam logic [N-1:0] MAXC  = MAXC_I[N-1:0];

    logic [N:0] diff;

    assign diff = {1'b0, raw_i} - {{(N + 1 - K){1'b0}}, ofs_i};

    always_ff @(posedge clk) begin
        if (rst) begin
            code_o  <= '0;
            clip_o  <= 1'b0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= load_i;
            if (load_i) begin
                if (diff[N]) begin
                    code_o <= '0;
                    clip_o <= 1'b1;
                end else if (diff[N-1:0] > MAXC) begin
                    code_o <= MAXC;
                    clip_o <= 1'b1;
                end else begin
                    code_o <= diff[N-1:0];
                    clip_o <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/slide_scale_corr.sv
module slide_scale_corr #(
    parameter int N = 8,
    parameter int K = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         conv_start_i,
    output logic [K-1:0] dither_code_o,
    output logic         dither_valid_o,
    input  logic [N-1:0] adc_code_i,
    input  logic         adc_done_i,
    output logic [N-1:0] out_code_o,
    output logic         out_valid_o,
    output logic         out_clip_o
);
    logic         take;
    logic         finish;
    logic         hold;
    logic [K-1:0] rnd_low;
    logic [K-1:0] ofs_q;

    ssc_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start_i  (conv_start_i),
        .done_i   (adc_done_i),
        .take_o   (take),
        .finish_o (finish),
        .hold_o   (hold)
    );

    ssc_lfsr #(.K(K)) u_lfsr (
        .clk   (clk),
        .rst   (rst),
        .adv_i (take),
        .low_o (rnd_low)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ofs_q <= '0;
        end else if (take) begin
            ofs_q <= rnd_low;
        end
    end

    ssc_corrector #(.N(N), .K(K)) u_corr (
        .clk     (clk),
        .rst     (rst),
        .load_i  (finish),
        .raw_i   (adc_code_i),
        .ofs_i   (ofs_q),
        .code_o  (out_code_o),
        .clip_o  (out_clip_o),
        .valid_o (out_valid_o)
    );

    assign dither_code_o  = ofs_q;
    assign dither_valid_o = hold;

endmodule

// File: rtl/ssc_checker.sv
module ssc_checker #(
    parameter int N = 8,
    parameter int K = 5
) (
    input logic         clk,
    input logic         rst,
    input logic         conv_start_i,
    input logic [K-1:0] dither_code_o,
    input logic         dither_valid_o,
    input logic [N-1:0] adc_code_i,
    input logic         adc_done_i,
    input logic [N-1:0] out_code_o,
    input logic         out_valid_o,
    input logic         out_clip_o
);
    localparam int          MAXC_I = (1 << N) - (1 << K);
    localparam logic [N-1:0] MAXC  = MAXC_I[N-1:0];

    a_r2_start_opens: assert property (@(posedge clk) disable iff (rst)
        (!dither_valid_o && conv_start_i) |=> dither_valid_o);

    a_r4_offset_stable: assert property (@(posedge clk) disable iff (rst)
        (dither_valid_o && !adc_done_i) |=> (dither_valid_o && $stable(dither_code_o)));

    a_r5_done_closes: assert property (@(posedge clk) disable iff (rst)
        (dither_valid_o && adc_done_i) |=> (out_valid_o && !dither_valid_o));

    a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
        out_valid_o |=> !out_valid_o);

    a_r7_within_range: assert property (@(posedge clk) disable iff (rst)
        out_valid_o |-> (out_code_o <= MAXC));

    a_r6_clip_at_end: assert property (@(posedge clk) disable iff (rst)
        (out_valid_o && out_clip_o) |-> (out_code_o == '0 || out_code_o == MAXC));

    a_r8_idle_done_ignored: assert property (@(posedge clk) disable iff (rst)
        !dither_valid_o |=> !out_valid_o);

    a_r9_result_held: assert property (@(posedge clk) disable iff (rst)
        !(dither_valid_o && adc_done_i) |=> ($stable(out_code_o) && $stable(out_clip_o)));

    // Raw code is a don't-care outside done cycles; referenced here for completeness.
    a_r5_raw_known: assert property (@(posedge clk) disable iff (rst)
        adc_done_i |-> !$isunknown(adc_code_i));

endmodule

bind slide_scale_corr ssc_checker #(.N(N), .K(K)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .conv_start_i   (conv_start_i),
    .dither_code_o  (dither_code_o),
    .dither_valid_o (dither_valid_o),
    .adc_code_i     (adc_code_i),
    .adc_done_i     (adc_done_i),
    .out_code_o     (out_code_o),
    .out_valid_o    (out_valid_o),
    .out_clip_o     (out_clip_o)
);

// File: tb/slide_scale_corr_test.sv
module slide_scale_corr_test;
    localparam int N    = 8;
    localparam int K    = 5;
    localparam int MAXC = (1 << N) - (1 << K);
    localparam int FULL = (1 << N) - 1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         conv_start_i = 1'b0;
    logic [K-1:0] dither_code_o;
    logic         dither_valid_o;
    logic [N-1:0] adc_code_i = '0;
    logic         adc_done_i = 1'b0;
    logic [N-1:0] out_code_o;
    logic         out_valid_o;
    logic         out_clip_o;

    slide_scale_corr #(.N(N), .K(K)) uut (
        .clk            (clk),
        .rst            (rst),
        .conv_start_i   (conv_start_i),
        .dither_code_o  (dither_code_o),
        .dither_valid_o (dither_valid_o),
        .adc_code_i     (adc_code_i),
        .adc_done_i     (adc_done_i),
        .out_code_o     (out_code_o),
        .out_valid_o    (out_valid_o),
        .out_clip_o     (out_clip_o)
    );

    always #10 clk = ~clk;   // 50 MHz

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  ended  = 0;

    // Reference model state: what the outputs should show after the last edge
    int  m_lfsr = 0;
    int  m_ofs  = 0;
    int  m_res  = 0;
    bit  m_busy = 0;
    bit  m_rv   = 0;
    bit  m_clip = 0;
    bit  m_first = 0;
    bit  m_after_rst = 0;
    bit  cmp_en = 0;
    int  n_r6 = 0;
    int  n_r7 = 0;

    function automatic int lfsr_next(input int s);
        int fb;
        fb = ((s >> 15) ^ (s >> 13) ^ (s >> 12) ^ (s >> 10)) & 1;
        return ((s << 1) & 16'hFFFF) | fb;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    task automatic compare();
        string t;
        if (!cmp_en) return;
        t = m_after_rst ? "R1" : (m_busy ? "R2" : "R5");
        chk(dither_valid_o === m_busy, t, int'(dither_valid_o), int'(m_busy));
        t = m_after_rst ? "R1" : (m_first ? "R3" : "R4");
        chk(dither_code_o === K'(m_ofs), t, int'(dither_code_o), m_ofs);
        t = m_after_rst ? "R1" : (m_rv ? "R5" : "R8");
        chk(out_valid_o === m_rv, t, int'(out_valid_o), int'(m_rv));
        if (m_after_rst) t = "R1";
        else if (!m_rv) t = "R9";
        else if (m_clip && m_res == 0) t = "R6";
        else if (m_clip) t = "R7";
        else t = "R5";
        if (m_rv && m_clip && m_res == 0) n_r6++;
        if (m_rv && m_clip && m_res == MAXC) n_r7++;
        chk(out_code_o === N'(m_res), t, int'(out_code_o), m_res);
        chk(out_clip_o === m_clip, t, int'(out_clip_o), int'(m_clip));
    endtask

    // One clock: compare current outputs, drive inputs, advance model over the next edge
    task automatic step(input bit rs, input bit st, input bit dn, input int rw);
        int d;
        @(negedge clk);
        compare();
        rst          = rs;
        conv_start_i = st;
        adc_done_i   = dn;
        adc_code_i   = N'(rw);
        m_first      = 0;
        m_after_rst  = 0;
        if (rs) begin
            m_lfsr = 16'hACE1; m_ofs = 0; m_res = 0;
            m_busy = 0; m_rv = 0; m_clip = 0;
            m_after_rst = 1;
            cmp_en = 1;
        end else begin
            m_rv = 0;
            if (m_busy && dn) begin
                d = rw - m_ofs;
                if (d < 0) begin m_res = 0; m_clip = 1; end
                else if (d > MAXC) begin m_res = MAXC; m_clip = 1; end
                else begin m_res = d; m_clip = 0; end
                m_rv = 1;
                m_busy = 0;
            end else if (!m_busy && st) begin
                m_ofs = m_lfsr & ((1 << K) - 1);
                m_lfsr = lfsr_next(m_lfsr);
                m_busy = 1;
                m_first = 1;
            end
        end
    endtask

    // kind 0: in-range input, 1: raw zero, 2: raw full scale
    task automatic convert(input int kind, input int gap, input bit noise_start);
        int rw;
        step(0, 1, 0, 0);
        for (int i = 0; i < gap; i++) begin
            step(0, noise_start && (i % 2 == 0), 0, 0);   // R3: starts while busy ignored
        end
        case (kind)
            1:       rw = 0;
            2:       rw = FULL;
            default: begin
                rw = $urandom_range(0, MAXC) + m_ofs;
                if (rw > FULL) rw = FULL;
            end
        endcase
        step(0, noise_start, 1, rw);
        step(0, 0, 0, 0);
    endtask

    initial begin
        for (int c = 0; c < 200000; c++) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
        finish_run();
    end

    initial begin
        step(1, 0, 0, 0);
        step(1, 0, 0, 0);
        step(0, 0, 0, 0);             // R1 state compared here
        // R6: first offset is seed low bits (1), raw 0 gives negative difference
        convert(1, 1, 0);
        // R8: done while idle
        step(0, 0, 1, 200);
        step(0, 0, 1, 17);
        step(0, 0, 0, 0);
        convert(0, 0, 0);
        convert(0, 3, 1);
        convert(2, 2, 0);             // R7 when offset is small
        for (int j = 0; j < 400; j++) begin
            convert(j % 3, j % 4, (j % 5) == 0);
            if (j % 7 == 0) step(0, 0, 1, $urandom_range(0, FULL));
        end
        // back-to-back start right after a result
        step(0, 1, 0, 0);
        step(0, 0, 1, 100 + m_ofs);
        step(0, 1, 0, 0);
        step(0, 0, 1, 0);
        step(0, 0, 0, 0);
        step(0, 0, 0, 0);
        chk(n_r6 > 0, "R6", n_r6, 1);
        chk(n_r7 > 0, "R7", n_r7, 1);
        finish_run();
    end

endmodule